// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Execution Unit

This unit executes the two instructions a small 32-bit CPU uses to build lock-free atomic sequences. The load-linked instruction reads one word from memory into R0 and arms a one-bit link flag. The store-conditional instruction writes R0 back only if the flag is still armed. It reports the outcome in the T bit of the status register and then disarms the flag. The link does not record an address. Interrupt and exception entry disarm it, and so does an address error raised by the unit itself.

The surrounding pipeline presents an instruction with a one-cycle start pulse and a 16-bit opcode. The unit reads the register file and the status register through dedicated read ports. It returns R0 and status updates as one-cycle write strobes. It talks to memory over a single-word request/valid port. When the feature-enable input is low, both opcodes are rejected as illegal.

Top module: `llsc_unit`

## Requirements
- R1: An opcode is recognised only when bits 15:12 are zero and bits 7:0 equal 0x63 (load-linked) or 0x73 (store-conditional). Bits 11:8 select the address register. Any other opcode produces no done, no illegal flag, no memory request and no change to the link.
- R2: Load-linked issues a read request at the address held in the selected register. When the read completes, it writes the returned word to R0 with a one-cycle r0_we strobe. It does not write the status register.
- R3: A completed load-linked arms the link, so a following store-conditional succeeds and writes R0 to the address in its selected register.
- R4: Store-conditional writes the status register once. Bit 0 (T) is set to the link value at the time of issue, and bits 31:1 keep their input values.
- R5: A store-conditional issued with the link disarmed makes no memory request, leaves T at 0, and asserts done in the cycle after it is accepted.
- R6: Every store-conditional disarms the link, so a second store-conditional fails.
- R7: An irq_take or exc_take pulse disarms the link.
- R8: With feat_en low, both opcodes raise illegal for one cycle. They make no memory request, write neither R0 nor status, and leave the link unchanged.
- R9: An address whose two low bits are not zero raises addr_err for one cycle. No memory access and no status write are made, and the link is disarmed.
- R10: A start pulse that arrives while an access is outstanding is ignored.
- R11: A memory request and its address, write flag and data stay stable until mem_valid. Done is asserted for exactly one cycle, in the cycle after mem_valid.
- R12: After reset the link is disarmed and every strobe and the memory request are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| feat_en | input | 1 | Enables recognition of both opcodes |
| start | input | 1 | One-cycle instruction start pulse |
| opcode | input | 16 | Instruction word |
| irq_take | input | 1 | Interrupt entry pulse |
| exc_take | input | 1 | Exception entry pulse |
| rf_raddr | output | 4 | Register file read index (address register) |
| rf_rdata | input | 32 | Register file read data |
| r0_rdata | input | 32 | Current value of R0 |
| r0_we | output | 1 | R0 write strobe |
| r0_wdata | output | 32 | R0 write data |
| sr_rdata | input | 32 | Current status register |
| sr_we | output | 1 | Status register write strobe |
| sr_wdata | output | 32 | Status register write data |
| mem_req | output | 1 | Memory request, held until mem_valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_valid | input | 1 | Access complete |
| mem_rdata | input | 32 | Read data, valid with mem_valid |
| done | output | 1 | Instruction complete |
| illegal | output | 1 | Opcode used while the feature is disabled |
| addr_err | output | 1 | Misaligned address exception |

## Verification
The assertions check, on every cycle, that T is copied from the link while the upper status bits pass through unchanged. They also check that interrupt, exception and store-conditional events leave the link disarmed on the next cycle, and that a completed load-linked arms it. Further checks cover the stability of a pending request, the one-cycle width of done, and the absence of side effects with illegal or addr_err. Only the bench scenarios can show the end-to-end meaning of the link. Examples are a store succeeding only after a completed load, a rejected opcode leaving the link armed, a start pulse ignored mid-access, and the data and address that actually reach memory across all registers and latencies.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    localparam int OPW      = 16;
    localparam int RIDX     = 4;
    localparam logic [7:0] LL_LOW = 8'h63;
    localparam logic [7:0] SC_LOW = 8'h73;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } state_e;

    typedef struct packed {
        logic            hit;
        logic            is_ll;
        logic            is_sc;
        logic [RIDX-1:0] areg;
    } dec_t;

    function automatic dec_t decode_op(input logic [OPW-1:0] op);
        dec_t d;
        d.is_ll = (op[15:12] == 4'h0) && (op[7:0] == LL_LOW);
        d.is_sc = (op[15:12] == 4'h0) && (op[7:0] == SC_LOW);
        d.hit   = d.is_ll | d.is_sc;
        d.areg  = op[11:8];
        return d;
    endfunction

endpackage

// File: rtl/llsc_decode.sv
module llsc_decode
    import llsc_pkg::*;
(
    input  logic [OPW-1:0] opcode,
    output dec_t           dec
);
    always_comb begin
        dec = decode_op(opcode);
    end
endmodule

// File: rtl/llsc_link.sv
module llsc_link (
    input  logic clk,
    input  logic rst,
    input  logic ll_begin,
    input  logic ll_fill,
    input  logic sc_begin,
    input  logic fault,
    input  logic irq_take,
    input  logic exc_take,
    output logic link
);
    logic clear_now;
    assign clear_now = ll_begin | sc_begin | fault | irq_take | exc_take;

    always_ff @(posedge clk) begin
        if (rst)            link <= 1'b0;
        else if (clear_now) link <= 1'b0;
        else if (ll_fill)   link <= 1'b1;
    end

    // R7: any interrupt or exception leaves the link disarmed
    p_event_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (irq_take || exc_take) |=> !link);
    // R6: a store-conditional always disarms the link
    p_sc_clears_r6: assert property (@(posedge clk) disable iff (rst)
        sc_begin |=> !link);
    // R3: a completed load arms the link when no event intervenes
    p_fill_arms_r3: assert property (@(posedge clk) disable iff (rst)
        (ll_fill && !irq_take && !exc_take && !sc_begin && !fault) |=> link);
endmodule

// File: rtl/llsc_ctrl.sv
module llsc_ctrl
    import llsc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            feat_en,
    input  logic            start,
    input  dec_t            dec,
    input  logic            link,
    input  logic [XLEN-1:0] rf_rdata,
    input  logic [XLEN-1:0] r0_rdata,
    input  logic [XLEN-1:0] sr_rdata,
    input  logic            mem_valid,
    input  logic [XLEN-1:0] mem_rdata,
    output logic            r0_we,
    output logic [XLEN-1:0] r0_wdata,
    output logic            sr_we,
    output logic [XLEN-1:0] sr_wdata,
    output logic            mem_req,
    output logic            mem_we,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    output logic            done,
    output logic            illegal,
    output logic            addr_err,
    output logic            ll_begin,
    output logic            ll_fill,
    output logic            sc_begin,
    output logic            fault
);
    localparam int ALIGN_BITS = 2;

    state_e state;
    logic   accept, allowed, misaligned;

    assign accept     = (state == ST_IDLE) && start && dec.hit;
    assign allowed    = accept && feat_en;
    assign misaligned = |rf_rdata[ALIGN_BITS-1:0];

    assign ll_begin = allowed && !misaligned && dec.is_ll;
    assign sc_begin = allowed && !misaligned && dec.is_sc;
    assign fault    = allowed && misaligned;
    assign ll_fill  = (state == ST_READ) && mem_valid;

    assign mem_req = (state != ST_IDLE);
    assign mem_we  = (state == ST_WRITE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            r0_we     <= 1'b0;
            r0_wdata  <= '0;
            sr_we     <= 1'b0;
            sr_wdata  <= '0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            done      <= 1'b0;
            illegal   <= 1'b0;
            addr_err  <= 1'b0;
        end else begin
            r0_we    <= 1'b0;
            sr_we    <= 1'b0;
            done     <= 1'b0;
            illegal  <= 1'b0;
            addr_err <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept && !feat_en) begin
                        illegal <= 1'b1;
                    end else if (fault) begin
                        addr_err <= 1'b1;
                    end else if (ll_begin) begin
                        state    <= ST_READ;
                        mem_addr <= rf_rdata;
                    end else if (sc_begin) begin
                        sr_we    <= 1'b1;
                        sr_wdata <= {sr_rdata[XLEN-1:1], link};
                        if (link) begin
                            state     <= ST_WRITE;
                            mem_addr  <= rf_rdata;
                            mem_wdata <= r0_rdata;
                        end else begin
                            done <= 1'b1;
                        end
                    end
                end
                ST_READ: begin
                    if (mem_valid) begin
                        r0_we    <= 1'b1;
                        r0_wdata <= mem_rdata;
                        done     <= 1'b1;
                        state    <= ST_IDLE;
                    end
                end
                ST_WRITE: begin
                    if (mem_valid) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R4: T reports the link as it stood at issue
    p_t_from_link_r4: assert property (@(posedge clk) disable iff (rst)
        sr_we |-> (sr_wdata[0] == $past(link)));
    // R4: upper status bits pass through
    p_sr_upper_kept_r4: assert property (@(posedge clk) disable iff (rst)
        sr_we |-> (sr_wdata[XLEN-1:1] == $past(sr_rdata[XLEN-1:1])));
    // R5: unlinked store-conditional issues no request
    p_no_store_unlinked_r5: assert property (@(posedge clk) disable iff (rst)
        (sc_begin && !link) |=> (!mem_req && done));
    // R11: pending request holds steady
    p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
    // R11: done lasts one cycle
    p_done_single_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R8: illegal has no side effects
    p_illegal_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!mem_req && !sr_we && !r0_we && !done));
    // R9: misaligned access has no side effects
    p_aerr_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        addr_err |-> (!mem_req && !sr_we && !r0_we && !done));
endmodule

// File: rtl/llsc_unit.sv
module llsc_unit
    import llsc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            feat_en,
    input  logic            start,
    input  logic [15:0]     opcode,
    input  logic            irq_take,
    input  logic            exc_take,
    output logic [3:0]      rf_raddr,
    input  logic [XLEN-1:0] rf_rdata,
    input  logic [XLEN-1:0] r0_rdata,
    output logic            r0_we,
    output logic [XLEN-1:0] r0_wdata,
    input  logic [XLEN-1:0] sr_rdata,
    output logic            sr_we,
    output logic [XLEN-1:0] sr_wdata,
    output logic            mem_req,
    output logic            mem_we,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    input  logic            mem_valid,
    input  logic [XLEN-1:0] mem_rdata,
    output logic            done,
    output logic            illegal,
    output logic            addr_err
);
    dec_t dec;
    logic link, ll_begin, ll_fill, sc_begin, fault;

    llsc_decode u_dec (
        .opcode (opcode),
        .dec    (dec)
    );

    assign rf_raddr = dec.areg;

    llsc_ctrl #(.XLEN(XLEN)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .feat_en   (feat_en),
        .start     (start),
        .dec       (dec),
        .link      (link),
        .rf_rdata  (rf_rdata),
        .r0_rdata  (r0_rdata),
        .sr_rdata  (sr_rdata),
        .mem_valid (mem_valid),
        .mem_rdata (mem_rdata),
        .r0_we     (r0_we),
        .r0_wdata  (r0_wdata),
        .sr_we     (sr_we),
        .sr_wdata  (sr_wdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .done      (done),
        .illegal   (illegal),
        .addr_err  (addr_err),
        .ll_begin  (ll_begin),
        .ll_fill   (ll_fill),
        .sc_begin  (sc_begin),
        .fault     (fault)
    );

    llsc_link u_link (
        .clk      (clk),
        .rst      (rst),
        .ll_begin (ll_begin),
        .ll_fill  (ll_fill),
        .sc_begin (sc_begin),
        .fault    (fault),
        .irq_take (irq_take),
        .exc_take (exc_take),
        .link     (link)
    );

    // R12: quiet after reset
    p_reset_quiet_r12: assert property (@(posedge clk)
        $past(rst) |-> (!mem_req && !done && !sr_we && !r0_we && !illegal && !addr_err));
endmodule

// File: tb/llsc_unit_tb.sv
module llsc_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        feat_en = 1'b1;
    logic        start = 1'b0;
    logic [15:0] opcode = '0;
    logic        irq_take = 1'b0, exc_take = 1'b0;
    logic [3:0]  rf_raddr;
    logic [31:0] rf_rdata, r0_rdata;
    logic        r0_we, sr_we, mem_req, mem_we, done, illegal, addr_err;
    logic [31:0] r0_wdata, sr_wdata, mem_addr, mem_wdata;
    logic        mem_valid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [31:0] regs [16];
    logic [31:0] sr_model = '0;

    int vectors = 0, fails = 0, cycles = 0;

    always #10 clk = ~clk;

    assign rf_rdata = regs[rf_raddr];
    assign r0_rdata = regs[0];

    llsc_unit u_dut (
        .clk(clk), .rst(rst), .feat_en(feat_en), .start(start), .opcode(opcode),
        .irq_take(irq_take), .exc_take(exc_take), .rf_raddr(rf_raddr),
        .rf_rdata(rf_rdata), .r0_rdata(r0_rdata), .r0_we(r0_we), .r0_wdata(r0_wdata),
        .sr_rdata(sr_model), .sr_we(sr_we), .sr_wdata(sr_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_valid(mem_valid), .mem_rdata(mem_rdata),
        .done(done), .illegal(illegal), .addr_err(addr_err)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 150000) begin
            fails++;
            $display("FAIL R11 watchdog expired: actual %0d cycles, expected fewer", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    // observation record of one instruction
    logic        o_done, o_ill, o_aerr, o_sr, o_r0, o_req, o_we, o_moved;
    logic [31:0] o_srv, o_r0v, o_addr, o_wd;
    int          o_done_at, o_done_cnt;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] op_ll(input int r);
        return 16'h0063 | 16'(r << 8);
    endfunction
    function automatic logic [15:0] op_sc(input int r);
        return 16'h0073 | 16'(r << 8);
    endfunction

    task automatic issue(input logic [15:0] op, input int lat, input logic [31:0] rd, input logic poke);
        int  waitc = 0;
        logic served = 1'b0, fin = 1'b0;
        o_done = 0; o_ill = 0; o_aerr = 0; o_sr = 0; o_r0 = 0; o_req = 0; o_we = 0; o_moved = 0;
        o_srv = '0; o_r0v = '0; o_addr = '0; o_wd = '0; o_done_at = -1; o_done_cnt = 0;
        @(negedge clk);
        start = 1'b1; opcode = op;
        @(negedge clk);
        for (int c = 0; c < 12 && !fin; c++) begin
            start = 1'b0; mem_valid = 1'b0;
            if (sr_we) begin o_sr = 1; o_srv = sr_wdata; sr_model = sr_wdata; end
            if (r0_we) begin o_r0 = 1; o_r0v = r0_wdata; regs[0] = r0_wdata; end
            if (illegal)  begin o_ill = 1; fin = 1; end
            if (addr_err) begin o_aerr = 1; fin = 1; end
            if (done) begin o_done = 1; o_done_cnt++; if (o_done_at < 0) o_done_at = c; fin = 1; end
            if (mem_req && !served) begin
                if (!o_req) begin o_req = 1; o_we = mem_we; o_addr = mem_addr; o_wd = mem_wdata; end
                else if (mem_addr != o_addr || mem_we != o_we || mem_wdata != o_wd) o_moved = 1;
                if (poke && waitc == 1) begin start = 1'b1; opcode = op_sc(3); end
                if (waitc == lat) begin mem_valid = 1'b1; mem_rdata = rd; served = 1'b1; end
                else waitc++;
            end
            @(negedge clk);
        end
        start = 1'b0; mem_valid = 1'b0;
        // one quiet cycle: catch duplicate done
        if (done) o_done_cnt++;
        @(negedge clk);
    endtask

    task automatic pulse_event(input logic is_irq);
        @(negedge clk);
        if (is_irq) irq_take = 1'b1; else exc_take = 1'b1;
        @(negedge clk);
        irq_take = 1'b0; exc_take = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) regs[i] = 32'h0000_1000 + 32'(i * 64);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12: reset state
        chk(!mem_req && !done && !sr_we && !r0_we && !illegal && !addr_err, "R12 outputs low after reset",
            {26'b0, mem_req, done, sr_we, r0_we, illegal, addr_err}, 32'h0);
        sr_model = 32'hFFFF_FFFF;
        issue(op_sc(1), 0, '0, 1'b0);
        chk(o_sr && o_srv == 32'hFFFF_FFFE, "R12 link disarmed after reset, T=0", o_srv, 32'hFFFF_FFFE);
        chk(!o_req, "R12 no store after reset", {31'b0, o_req}, 32'h0);

        // R2 R3 R4 R5 R6 R11: sweep registers and latencies
        for (int n = 0; n < 16; n++) begin
            for (int lat = 0; lat < 4; lat++) begin
                logic [31:0] a_ll, rd, a_sc, srv;
                int m;
                m    = 15 - n;
                a_ll = 32'h1000_0000 + 32'(n * 256) + 32'(lat * 16);
                rd   = 32'h8000_0000 | 32'(n << 12) | 32'(lat << 4) | 32'h0000_0100;
                regs[n] = a_ll;
                if (m != 0) regs[m] = 32'h2000_0000 + 32'(m * 64) + 32'(lat * 4);
                issue(op_ll(n), lat, rd, 1'b0);
                chk(o_req && !o_we && o_addr == a_ll, "R2 read request address", o_addr, a_ll);
                chk(o_r0 && o_r0v == rd && !o_sr, "R2 R0 receives loaded word", o_r0v, rd);
                chk(o_done_at == lat + 1 && o_done_cnt == 1 && !o_moved, "R11 done one cycle after valid",
                    32'(o_done_at), 32'(lat + 1));
                a_sc = (m == 0) ? rd : regs[m];
                srv  = (32'h5A00_0000 ^ 32'(n << 8) ^ 32'(lat << 20)) & 32'hFFFF_FFFE;
                sr_model = srv;
                issue(op_sc(m), lat, '0, 1'b0);
                chk(o_sr && o_srv == (srv | 32'h1), "R4 T set, upper status kept", o_srv, srv | 32'h1);
                chk(o_req && o_we && o_addr == a_sc && o_wd == rd, "R3 linked store writes R0", o_wd, rd);
                chk(o_done_at == lat + 1 && o_done_cnt == 1 && !o_moved, "R11 store completes after valid",
                    32'(o_done_at), 32'(lat + 1));
                sr_model = srv | 32'h1;
                issue(op_sc(m), 0, '0, 1'b0);
                chk(o_sr && o_srv == srv, "R6 second store fails, T=0", o_srv, srv);
                chk(!o_req && o_done_at == 0, "R5 failed store: no request, immediate done",
                    {31'b0, o_req}, 32'h0);
            end
        end

        // R7: interrupt and exception disarm the link
        regs[1] = 32'h0000_4000; regs[2] = 32'h0000_5000;
        for (int k = 0; k < 2; k++) begin
            issue(op_ll(1), 1, 32'h0000_7770, 1'b0);
            pulse_event(k == 0);
            issue(op_sc(2), 0, '0, 1'b0);
            chk(o_sr && o_srv[0] == 1'b0 && !o_req, k == 0 ? "R7 irq disarms link" : "R7 exception disarms link",
                {31'b0, o_srv[0]}, 32'h0);
        end

        // R8: disabled feature
        regs[1] = 32'h0000_4000;
        issue(op_ll(1), 0, 32'h0000_1230, 1'b0);
        feat_en = 1'b0;
        issue(op_sc(2), 0, '0, 1'b0);
        chk(o_ill && !o_req && !o_sr && !o_done, "R8 disabled store-conditional is illegal", {31'b0, o_ill}, 32'h1);
        issue(op_ll(1), 0, 32'h0000_9990, 1'b0);
        chk(o_ill && !o_req && !o_r0, "R8 disabled load-linked is illegal", {31'b0, o_ill}, 32'h1);
        feat_en = 1'b1;
        issue(op_sc(2), 0, '0, 1'b0);
        chk(o_sr && o_srv[0] && o_req && o_wd == 32'h0000_1230, "R8 link untouched by rejected opcodes",
            o_wd, 32'h0000_1230);

        // R9: misaligned addresses
        for (int lo = 1; lo < 4; lo++) begin
            regs[3] = 32'h0000_6000 | 32'(lo);
            issue(op_ll(1), 0, 32'h0000_2220, 1'b0);
            issue(op_sc(3), 0, '0, 1'b0);
            chk(o_aerr && !o_req && !o_sr && !o_done, "R9 misaligned store raises addr_err", {31'b0, o_aerr}, 32'h1);
            issue(op_sc(2), 0, '0, 1'b0);
            chk(o_sr && !o_srv[0] && !o_req, "R9 address error disarms link", {31'b0, o_srv[0]}, 32'h0);
            issue(op_ll(3), 0, 32'h0000_3330, 1'b0);
            chk(o_aerr && !o_req && !o_r0, "R9 misaligned load raises addr_err", {31'b0, o_aerr}, 32'h1);
        end

        // R10: start while busy is ignored
        regs[3] = 32'h0000_6000;
        issue(op_ll(1), 3, 32'h0000_4440, 1'b1);
        chk(o_done_cnt == 1 && !o_we && !o_sr && !o_moved, "R10 start during access ignored",
            32'(o_done_cnt), 32'h1);
        issue(op_sc(2), 0, '0, 1'b0);
        chk(o_sr && o_srv[0] && o_req, "R10 link survives ignored start", {31'b0, o_srv[0]}, 32'h1);

        // R1: foreign opcodes ignored
        issue(op_ll(1), 0, 32'h0000_5550, 1'b0);
        begin
            logic [15:0] bad [5];
            bad[0] = 16'h1163; bad[1] = 16'h0064; bad[2] = 16'hF173; bad[3] = 16'h0083; bad[4] = 16'h0272;
            for (int b = 0; b < 5; b++) begin
                issue(bad[b], 0, '0, 1'b0);
                chk(!o_done && !o_ill && !o_aerr && !o_req && !o_sr, "R1 foreign opcode ignored",
                    {27'b0, o_done, o_ill, o_aerr, o_req, o_sr}, 32'h0);
            end
        end
        issue(op_sc(2), 0, '0, 1'b0);
        chk(o_sr && o_srv[0] && o_wd == 32'h0000_5550, "R1 link kept across foreign opcodes", o_wd, 32'h0000_5550);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule